// File: doc/BRIEF.md
# Register Result Latency Scoreboard

This block tells an in-order issue stage whether the source registers of a candidate instruction hold results that the instruction may use yet. It covers an integer file and a floating-point file of equal size. When a result-producing instruction issues, the issue logic presents its destination and its producer class. The block then loads that register's counter with the class's full result latency, and the counter counts down one step per clock until it reaches zero.

A readiness query names a consumer class and up to two source registers. For each source the block takes the latency that applies to that particular pairing of producer class and consumer class. A forwarding path can make the pairing shorter than the producer's full latency. An operand is usable once the cycles elapsed since the producer issued reach that pairing latency. Because the counter starts at the full latency, this test reduces to one compare per operand: the remaining count must not exceed the full latency minus the pairing latency. The answer is combinational, and it reflects producers that issued on earlier clock edges.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset, every register in both files reports ready to every consumer class.
- R2: Register addresses are 6 bits: bit 5 selects the file (0 integer, 1 floating point) and bits 4:0 give the index. Producer codes: 0 load, 1 branch/link, 2 add/logic, 3 shift/conditional move, 4 compare, 5 32-bit multiply, 6 64-bit multiply, 7 ordinary FP operation, 8 single divide, 9 double divide. Consumer codes: 0 other, 1 branch, 2 add/logic, 3 shift/conditional move, 4 compare, 5 multiply, 6 ordinary FP operation, 7 integer store. After a producer issues on edge t, a source that names its register becomes ready when the number of later edges is at least the pairing latency, and it stays ready from then on. Shift/conditional move producers need 2 cycles for every consumer except store data.
- R3: An add/logic result needs 1 cycle when the consumer is branch, add/logic, shift/conditional move, compare or multiply, and 2 cycles otherwise.
- R4: A compare result needs 1 cycle for a branch consumer and 2 cycles for any other consumer.
- R5: When the consumer is an integer store, source 1 is the data operand and source 0 is the address operand. Add/logic, shift and compare results need 0 cycles as store data, but their normal latency as a store address.
- R6: A 32-bit multiply result needs 21 cycles, or 20 as store data. A 64-bit multiply result needs 23 cycles, or 22 as store data.
- R7: An ordinary FP result needs 6 cycles, or 4 when the consumer is also an ordinary FP operation.
- R8: Single divide needs 34 cycles and double divide needs 63 cycles. A load needs 1 cycle and a branch/link result needs 2 cycles, whatever the consumer.
- R9: Index 31 of each file always reports ready, and an issue that targets it has no effect.
- R10: A new producer to a register replaces the pending one, so readiness then follows only the newer producer's class and issue time.
- R11: A source whose use flag is low reports ready. The overall ready output is the AND of the two per-source results.
- R12: An issue to an index in one file leaves the same index in the other file unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A producer issues this cycle |
| iss_dest | input | 6 | Destination register address (file bit and index) |
| iss_cls | input | 4 | Producer class code |
| q_cls | input | 3 | Consumer class code of the queried instruction |
| q_use0 | input | 1 | Source 0 is read by the consumer |
| q_src0 | input | 6 | Source 0 register address (store address for integer stores) |
| q_use1 | input | 1 | Source 1 is read by the consumer |
| q_src1 | input | 6 | Source 1 register address (store data for integer stores) |
| q_rdy0 | output | 1 | Source 0 may be used this cycle |
| q_rdy1 | output | 1 | Source 1 may be used this cycle |
| q_ready | output | 1 | Both sources may be used this cycle |

## Verification
The query outputs are combinational, so a query is judged in the same cycle that it is presented. Its result depends only on how many clock edges have passed since the producer's issue edge. The bench issues on one edge and calls the sampling point just after the following falling edge elapsed count 0, then moves up by one per clock. For every producer-consumer pairing and both operand roles, it records the first count at which each source reports ready. It also confirms that the source never drops back to not-ready. That first count must equal the pairing latency, which the bench computes itself. Overwrite, file separation and the hardwired index are checked at counts 0 and 1 after their issue edges.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

  // counter width: the longest full latency (63) must fit
  localparam int LAT_W = 6;

  typedef enum logic [3:0] {
    P_LOAD   = 4'd0,
    P_BRANCH = 4'd1,
    P_ALU    = 4'd2,
    P_SHIFT  = 4'd3,
    P_CMP    = 4'd4,
    P_MUL32  = 4'd5,
    P_MUL64  = 4'd6,
    P_FPOP   = 4'd7,
    P_FDIVS  = 4'd8,
    P_FDIVD  = 4'd9
  } pcls_e;

  typedef enum logic [2:0] {
    C_OTHER  = 3'd0,
    C_BRANCH = 3'd1,
    C_ALU    = 3'd2,
    C_SHIFT  = 3'd3,
    C_CMP    = 3'd4,
    C_MUL    = 3'd5,
    C_FPOP   = 3'd6,
    C_ISTORE = 3'd7
  } ccls_e;

  // latency seen by a consumer with no forwarding path
  function automatic logic [LAT_W-1:0] full_lat(input pcls_e p);
    logic [LAT_W-1:0] r;
    case (p)
      P_LOAD:   r = LAT_W'(1);
      P_BRANCH: r = LAT_W'(2);
      P_ALU:    r = LAT_W'(2);
      P_SHIFT:  r = LAT_W'(2);
      P_CMP:    r = LAT_W'(2);
      P_MUL32:  r = LAT_W'(21);
      P_MUL64:  r = LAT_W'(23);
      P_FPOP:   r = LAT_W'(6);
      P_FDIVS:  r = LAT_W'(34);
      P_FDIVD:  r = LAT_W'(63);
      default:  r = LAT_W'(1);
    endcase
    return r;
  endfunction

  // latency for one producer/consumer pairing; is_data marks store data
  function automatic logic [LAT_W-1:0] pair_lat(input pcls_e p, input ccls_e c,
                                                input logic is_data);
    logic [LAT_W-1:0] r;
    logic int_fast;
    int_fast = (c == C_BRANCH) || (c == C_ALU) || (c == C_SHIFT) ||
               (c == C_CMP) || (c == C_MUL);
    r = full_lat(p);
    case (p)
      P_ALU:   r = is_data ? LAT_W'(0) : (int_fast ? LAT_W'(1) : LAT_W'(2));
      P_SHIFT: r = is_data ? LAT_W'(0) : LAT_W'(2);
      P_CMP:   r = is_data ? LAT_W'(0) : ((c == C_BRANCH) ? LAT_W'(1) : LAT_W'(2));
      P_MUL32: r = is_data ? LAT_W'(20) : LAT_W'(21);
      P_MUL64: r = is_data ? LAT_W'(22) : LAT_W'(23);
      P_FPOP:  r = (c == C_FPOP) ? LAT_W'(4) : LAT_W'(6);
      default: r = full_lat(p);
    endcase
    return r;
  endfunction

  // largest remaining count at which the pairing is already satisfied
  function automatic logic [LAT_W-1:0] pair_slack(input pcls_e p, input ccls_e c,
                                                  input logic is_data);
    return full_lat(p) - pair_lat(p, c, is_data);
  endfunction

endpackage

// File: rtl/lsb_entry.sv
module lsb_entry
  import lsb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  pcls_e            load_cls,
  output logic [LAT_W-1:0] remain,
  output pcls_e            cls
);

  logic counting;
  assign counting = (remain != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      cls    <= P_LOAD;
    end else if (load) begin
      remain <= full_lat(load_cls);
      cls    <= load_cls;
    end else if (counting) begin
      remain <= remain - 1'b1;
    end
  end

  AST_LOAD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (remain != '0)); // R2

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && counting) |=> (remain == $past(remain) - 1'b1)); // R2

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !counting) |=> (remain == '0)); // R10

endmodule

// File: rtl/lsb_src_check.sv
module lsb_src_check
  import lsb_pkg::*;
#(
  parameter bit DATA_ROLE = 1'b0
)(
  input  logic             use_i,
  input  ccls_e            ccls,
  input  logic [LAT_W-1:0] remain,
  input  pcls_e            pcls,
  output logic             rdy
);

  logic             is_data;
  logic [LAT_W-1:0] slack;

  assign is_data = DATA_ROLE && (ccls == C_ISTORE);
  assign slack   = pair_slack(pcls, ccls, is_data);
  assign rdy     = !use_i || (remain <= slack);

endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
  import lsb_pkg::*;
#(
  parameter int NREGS = 32
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       iss_valid,
  input  logic [$clog2(NREGS):0]     iss_dest,
  input  logic [3:0]                 iss_cls,
  input  logic [2:0]                 q_cls,
  input  logic                       q_use0,
  input  logic [$clog2(NREGS):0]     q_src0,
  input  logic                       q_use1,
  input  logic [$clog2(NREGS):0]     q_src1,
  output logic                       q_rdy0,
  output logic                       q_rdy1,
  output logic                       q_ready
);

  localparam int AW   = $clog2(NREGS) + 1;
  localparam int NTOT = 2 * NREGS;
  localparam int ZIDX = NREGS - 1;

  logic [LAT_W-1:0] rem_q [NTOT];
  pcls_e            cls_q [NTOT];
  logic [NTOT-1:0]  ld;

  pcls_e iss_cls_e;
  ccls_e q_cls_e;
  assign iss_cls_e = pcls_e'(iss_cls);
  assign q_cls_e   = ccls_e'(q_cls);

  for (genvar gi = 0; gi < NTOT; gi++) begin : g_reg
    if ((gi % NREGS) == ZIDX) begin : g_zero
      assign ld[gi] = 1'b0;
    end else begin : g_live
      assign ld[gi] = iss_valid && (iss_dest == AW'(gi));
    end
    lsb_entry u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld[gi]),
      .load_cls (iss_cls_e),
      .remain   (rem_q[gi]),
      .cls      (cls_q[gi])
    );
  end

  // selected per-source state, brought out for the checks below
  logic [LAT_W-1:0] sel_rem0, sel_rem1;
  pcls_e            sel_cls0, sel_cls1;
  assign sel_rem0 = rem_q[q_src0];
  assign sel_rem1 = rem_q[q_src1];
  assign sel_cls0 = cls_q[q_src0];
  assign sel_cls1 = cls_q[q_src1];

  lsb_src_check #(.DATA_ROLE(1'b0)) u_src0 (
    .use_i  (q_use0),
    .ccls   (q_cls_e),
    .remain (sel_rem0),
    .pcls   (sel_cls0),
    .rdy    (q_rdy0)
  );

  lsb_src_check #(.DATA_ROLE(1'b1)) u_src1 (
    .use_i  (q_use1),
    .ccls   (q_cls_e),
    .remain (sel_rem1),
    .pcls   (sel_cls1),
    .rdy    (q_rdy1)
  );

  assign q_ready = q_rdy0 && q_rdy1;

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rem0 == '0) |-> q_rdy0); // R2

  AST_ZERO_INDEX_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_src1[AW-2:0] == (AW-1)'(ZIDX)) |-> q_rdy1); // R9

endmodule

// File: tb/lat_scoreboard_bench.sv
`timescale 1ns/1ps
module lat_scoreboard_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0;
  logic [5:0] iss_dest = '0;
  logic [3:0] iss_cls = '0;
  logic [2:0] q_cls = '0;
  logic       q_use0 = 1'b0;
  logic [5:0] q_src0 = '0;
  logic       q_use1 = 1'b0;
  logic [5:0] q_src1 = '0;
  logic       q_rdy0, q_rdy1, q_ready;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lat_scoreboard u_lat_scoreboard (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dest(iss_dest),
    .iss_cls(iss_cls), .q_cls(q_cls), .q_use0(q_use0), .q_src0(q_src0),
    .q_use1(q_use1), .q_src1(q_src1), .q_rdy0(q_rdy0), .q_rdy1(q_rdy1),
    .q_ready(q_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent restatement of the pairing latencies
  function automatic int want(input int p, input int c, input int role);
    bit sdata = (c == 7) && (role == 1);
    int base [10] = '{1, 2, 2, 2, 2, 21, 23, 6, 34, 63};
    if (sdata && (p >= 2) && (p <= 4)) return 0;
    if (sdata && (p == 5 || p == 6)) return base[p] - 1;
    if (p == 2 && c >= 1 && c <= 5) return 1;
    if (p == 4 && c == 1) return 1;
    if (p == 7 && c == 6) return 4;
    return base[p];
  endfunction

  function automatic string tag(input int p, input int c, input int role);
    if ((c == 7) && (role == 1) && (p >= 2) && (p <= 4)) return "R5";
    if (c == 7 && p >= 2 && p <= 4) return "R5";
    case (p)
      2: return "R3";
      3: return "R2";
      4: return "R4";
      5, 6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  // issue on the next rising edge; returns at the falling edge after it
  task automatic issue(input logic [5:0] d, input int p);
    @(negedge clk);
    iss_valid = 1'b1; iss_dest = d; iss_cls = 4'(p);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: everything ready after reset, for several consumer classes
    for (int a = 0; a < 64; a++) begin
      q_cls = 3'(a % 8); q_use0 = 1'b1; q_src0 = 6'(a); q_use1 = 1'b1; q_src1 = 6'(63 - a);
      #1;
      check(q_rdy0 && q_rdy1 && q_ready, "R1", {q_rdy0, q_rdy1, q_ready}, 7);
    end

    // pairing sweep, R2..R8
    for (int p = 0; p < 10; p++) begin
      for (int c = 0; c < 8; c++) begin
        logic [5:0] d;
        int f0, f1;
        bit mono0, mono1;
        d = (p >= 7) ? 6'd39 : 6'd7;
        f0 = -1; f1 = -1; mono0 = 1'b1; mono1 = 1'b1;
        issue(d, p);
        for (int k = 0; k < 66; k++) begin
          q_cls = 3'(c); q_use0 = 1'b1; q_src0 = d; q_use1 = 1'b1; q_src1 = d;
          #1;
          if (q_rdy0 && f0 < 0) f0 = k;
          if (!q_rdy0 && f0 >= 0) mono0 = 1'b0;
          if (q_rdy1 && f1 < 0) f1 = k;
          if (!q_rdy1 && f1 >= 0) mono1 = 1'b0;
          @(negedge clk);
        end
        check(mono0 && f0 == want(p, c, 0), tag(p, c, 0), f0, want(p, c, 0));
        check(mono1 && f1 == want(p, c, 1), tag(p, c, 1), f1, want(p, c, 1));
      end
    end

    // R9: hardwired index in both files
    issue(6'd31, 9);
    issue(6'd63, 9);
    q_cls = 3'd0; q_use0 = 1'b1; q_src0 = 6'd31; q_use1 = 1'b1; q_src1 = 6'd63;
    #1;
    check(q_rdy0, "R9", q_rdy0, 1);
    check(q_rdy1, "R9", q_rdy1, 1);

    // R10: a load replaces a pending double divide
    issue(6'd5, 9);
    repeat (3) @(negedge clk);
    issue(6'd5, 0);
    q_cls = 3'd0; q_use0 = 1'b1; q_src0 = 6'd5; q_use1 = 1'b0; q_src1 = 6'd0;
    #1;
    check(!q_rdy0, "R10", q_rdy0, 0);
    @(negedge clk);
    #1;
    check(q_rdy0, "R10", q_rdy0, 1);

    // R12: same index in the other file
    issue(6'd37, 9);
    q_cls = 3'd0; q_use0 = 1'b1; q_src0 = 6'd5; q_use1 = 1'b1; q_src1 = 6'd37;
    #1;
    check(q_rdy0, "R12", q_rdy0, 1);
    check(!q_rdy1, "R12", q_rdy1, 0);

    // R11: unused sources and the combined output
    q_use0 = 1'b0; q_src0 = 6'd37; q_use1 = 1'b1; q_src1 = 6'd5;
    #1;
    check(q_rdy0 && q_ready, "R11", {q_rdy0, q_ready}, 3);
    q_use0 = 1'b1;
    #1;
    check(!q_rdy0 && !q_ready && q_rdy1, "R11", {q_rdy0, q_ready, q_rdy1}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule